// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block holds the control state and item counter for one channel of a DMA controller. Software programs it through a small register port. One register holds the channel settings: enable, source direction, circular operation and three interrupt enables. A second register holds the 16-bit number of items to move. The flag register reports three events, and a fourth address clears flags by writing ones.

An external transfer engine uses `req_ok` to decide whether it may start an item. It pulses `xfer_done` after each item it completes, and `xfer_err` when a transfer faults. The block counts items down and raises the half-way, done and error flags. It drives one interrupt line from those flags and the interrupt enables.

In circular operation the counter reloads the last value software wrote when it reaches zero, so the channel keeps running. Without circular operation the counter stays at zero. The channel then stays enabled but asks for no more transfers.

Top module: `dma_chan_counter`

## Requirements
- R1: After reset the settings, counter, reload value and all flags are zero, so `req_ok` and `irq` are low and every register reads zero.
- R2: A write to address 0 stores `wr_data[5:0]` as the settings: bit 0 enable, bit 1 done-interrupt enable, bit 2 half-interrupt enable, bit 3 error-interrupt enable, bit 4 direction, bit 5 circular. A read of address 0 returns these bits with all upper bits zero. `dir_mem` follows bit 4: 1 means the source is memory, 0 means the source is the peripheral.
- R3: A write to address 1 loads `wr_data[15:0]` into both the counter and the reload value, but only while the enable bit is 0. While the enable bit is 1 such a write has no effect. A read of address 1 returns the live count with bits 31:16 zero.
- R4: `req_ok` is high exactly when the enable bit is 1 and the count is nonzero.
- R5: A `xfer_done` pulse while `req_ok` is high lowers the count by one in the next cycle. A pulse while `req_ok` is low changes nothing.
- R6: With circular off, a count that reaches zero stays at zero. The enable bit stays 1 and `req_ok` goes low.
- R7: With circular on, a decrement that would reach zero loads the reload value into the counter instead.
- R8: The done flag (flag bit 0) sets on an accepted `xfer_done` whose decrement reaches zero. This includes a circular reload.
- R9: The half flag (flag bit 1) sets on an accepted `xfer_done` whose decremented count equals the reload value shifted right by one.
- R10: A `xfer_err` pulse sets the error flag (flag bit 2) and clears the enable bit. The error wins over a settings write in the same cycle.
- R11: A write to address 3 clears each flag whose bit in `wr_data` is 1. A flag set in the same cycle stays set. Address 2 reads the flags in bits 2:0.
- R12: `irq` is high when any flag is set together with its interrupt enable: done with bit 1, half with bit 2, error with bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 settings, 1 count, 3 flag clear |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 settings, 1 count, 2 flags |
| rd_data | output | 32 | Read data, combinational |
| xfer_done | input | 1 | One item completed by the engine |
| xfer_err | input | 1 | Transfer error from the engine |
| req_ok | output | 1 | Engine may start an item |
| remaining | output | 16 | Live count of items still to move |
| dir_mem | output | 1 | Source select: 1 memory, 0 peripheral |
| flag_tc | output | 1 | Done flag |
| flag_ht | output | 1 | Half flag |
| flag_te | output | 1 | Error flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench tries to rewrite the count while the channel is enabled. A design that fails to lock the counter would show the new value. It pulses `xfer_done` at zero count and while disabled. A counter that wraps to 65535 or keeps counting would be caught there.

Circular runs cross several reloads. A design that reloads one item late, or reloads zero, would drift from the bench's model. The bench also raises a flag in the same cycle that software clears it, and injects an error while the channel is busy. A design that lets the clear win, or leaves the channel enabled after an error, mismatches on the next cycle.

// File: rtl/dma_chan_counter.sv
module dma_chan_counter #(
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          xfer_done,
  input  logic          xfer_err,
  output logic          req_ok,
  output logic [CW-1:0] remaining,
  output logic          dir_mem,
  output logic          flag_tc,
  output logic          flag_ht,
  output logic          flag_te,
  output logic          irq
);
  localparam logic [1:0] A_CFG = 2'd0, A_CNT = 2'd1, A_FLG = 2'd2, A_CLR = 2'd3;

  logic [5:0]    cfg;
  logic [CW-1:0] cnt, shadow;
  logic          tc, ht, te;

  wire           en    = cfg[0];
  wire           wr_cf = wr_en && wr_addr == A_CFG;
  wire           wr_ct = wr_en && wr_addr == A_CNT && !en;
  wire           wr_cl = wr_en && wr_addr == A_CLR;
  wire           take  = req_ok && xfer_done;
  wire [CW-1:0]  nxt   = cnt - 1'b1;
  wire           last  = nxt == '0;

  assign req_ok    = en && (cnt != '0);
  assign remaining = cnt;
  assign dir_mem   = cfg[4];
  assign flag_tc   = tc;
  assign flag_ht   = ht;
  assign flag_te   = te;
  assign irq       = (tc && cfg[1]) || (ht && cfg[2]) || (te && cfg[3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      cnt    <= '0;
      shadow <= '0;
      tc     <= 1'b0;
      ht     <= 1'b0;
      te     <= 1'b0;
    end else begin
      if (wr_cf) cfg <= wr_data[5:0];
      if (xfer_err) cfg[0] <= 1'b0;

      if (wr_ct) begin
        cnt    <= wr_data[CW-1:0];
        shadow <= wr_data[CW-1:0];
      end else if (take) begin
        cnt <= (last && cfg[5]) ? shadow : nxt;
      end

      if (wr_cl) begin
        if (wr_data[0]) tc <= 1'b0;
        if (wr_data[1]) ht <= 1'b0;
        if (wr_data[2]) te <= 1'b0;
      end
      if (take && last)               tc <= 1'b1;
      if (take && nxt == (shadow >> 1)) ht <= 1'b1;
      if (xfer_err)                   te <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CFG:   rd_data[5:0]    = cfg;
      A_CNT:   rd_data[CW-1:0] = cnt;
      A_FLG:   rd_data[2:0]    = {te, ht, tc};
      default: rd_data         = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_counter_chk.sv
module dma_chan_counter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          xfer_done,
  input logic          xfer_err,
  input logic          req_ok,
  input logic [CW-1:0] remaining,
  input logic          flag_tc,
  input logic          flag_te,
  input logic [5:0]    cfg
);
  assert_permit_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |-> (remaining != '0 && cfg[0]));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ok && !(wr_en && wr_addr == 2'd1)) |=> $stable(remaining));

  assert_locked_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && wr_en && wr_addr == 2'd1 && !xfer_done) |=> $stable(remaining));

  assert_stop_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && xfer_done && remaining == 1 && !cfg[5]) |=> (remaining == '0 && !req_ok));

  assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && xfer_done && remaining == 1) |=> flag_tc);

  assert_error_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> (flag_te && !cfg[0] && !req_ok));
endmodule

bind dma_chan_counter dma_chan_counter_chk #(.CW(CW)) u_chk (.*);

// File: tb/dma_chan_counter_test.sv
module dma_chan_counter_test;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, xfer_done = 0, xfer_err = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        req_ok, dir_mem, flag_tc, flag_ht, flag_te, irq;
  logic [15:0] remaining;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  int m_cfg, m_cnt, m_sh, m_tc, m_ht, m_te;

  dma_chan_counter uut (.*);

  always #2 clk = ~clk;

  task automatic chk(string tag, longint got, longint exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    int rd_exp;
    chk("R5 remaining", remaining, m_cnt);
    chk("R4 req_ok", req_ok, ((m_cfg & 1) != 0) && m_cnt != 0);
    chk("R2 dir_mem", dir_mem, (m_cfg >> 4) & 1);
    chk("R8 flag_tc", flag_tc, m_tc);
    chk("R9 flag_ht", flag_ht, m_ht);
    chk("R10 flag_te", flag_te, m_te);
    chk("R12 irq", irq, (m_tc && (m_cfg & 2)) || (m_ht && (m_cfg & 4)) || (m_te && (m_cfg & 8)));
    case (rd_addr)
      0: rd_exp = m_cfg;
      1: rd_exp = m_cnt;
      2: rd_exp = (m_te << 2) | (m_ht << 1) | m_tc;
      default: rd_exp = 0;
    endcase
    chk(rd_addr == 1 ? "R3 rd_count" : rd_addr == 2 ? "R11 rd_flags" : "R2 rd_cfg", rd_data, rd_exp);
  endtask

  task automatic step(bit we, int wa, int wd, bit dn, bit er, int ra);
    bit en, take, last;
    int nxt;
    wr_en = we; wr_addr = wa[1:0]; wr_data = wd; xfer_done = dn; xfer_err = er; rd_addr = ra[1:0];
    en   = (m_cfg & 1) != 0;
    take = en && m_cnt != 0 && dn;
    nxt  = m_cnt - 1;
    last = take && nxt == 0;
    if (we && wa == 3) begin
      if (wd & 1) m_tc = 0;
      if (wd & 2) m_ht = 0;
      if (wd & 4) m_te = 0;
    end
    if (last) m_tc = 1;
    if (take && nxt == m_sh / 2) m_ht = 1;
    if (er) m_te = 1;
    if (we && wa == 1 && !en) begin m_cnt = wd & 16'hffff; m_sh = m_cnt; end
    else if (take) m_cnt = (last && (m_cfg & 32)) ? m_sh : nxt;
    if (we && wa == 0) m_cfg = wd & 6'h3f;
    if (er) m_cfg = m_cfg & ~1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; xfer_done = 0; xfer_err = 0;
    compare_all();
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_cfg = 0; m_cnt = 0; m_sh = 0; m_tc = 0; m_ht = 0; m_te = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state over every read address
    for (int a = 0; a < 4; a++) begin
      rd_addr = a[1:0]; #0.5;
      chk("R1 reset rd_data", rd_data, 0);
    end
    chk("R1 reset req_ok", req_ok, 0);
    chk("R1 reset irq", irq, 0);

    // R2 settings, upper bits dropped, direction
    step(1, 0, 32'hffff_ffd0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0);              // R5: done while disabled ignored
    step(1, 1, 32'hdead_0008, 0, 0, 1);  // R3 count load
    step(1, 0, 32'h07, 0, 0, 1);         // enable + tc/ht irq
    step(1, 1, 3, 0, 0, 1);              // R3 locked write
    chk("R3 locked count", remaining, 8);
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 1, 0, 2);
      step(0, 0, 0, 0, 0, 1);
    end
    chk("R9 half seen", flag_ht, 1);
    chk("R6 stays enabled", rd_data[0] | 1'b0, 0);
    step(0, 0, 0, 1, 0, 0);              // R6 done at zero ignored
    chk("R6 held zero", remaining, 0);
    chk("R6 enable kept", rd_data[0], 1);
    step(1, 3, 1, 0, 0, 2);              // R11 clear tc only
    step(1, 3, 7, 0, 0, 2);

    // R7 circular
    step(1, 0, 0, 0, 0, 0);
    step(1, 1, 5, 0, 0, 1);
    step(1, 0, 32'h23, 0, 0, 1);
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 0, 1);
    chk("R7 reloaded count", remaining, 3);
    // R11 clear with simultaneous set: next done from 3 does not hit, so run to 1
    step(0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 1, 0, 1);
    step(1, 3, 1, 1, 0, 2);              // clear tc while it sets again
    chk("R11 set wins", flag_tc, 1);

    // R10 error while running
    step(1, 0, 32'h2b, 0, 0, 0);
    step(1, 0, 32'h2f, 0, 1, 0);         // error beats enable write
    chk("R10 enable cleared", req_ok, 0);
    step(1, 3, 7, 0, 0, 2);
    // R4 zero count enabled
    step(1, 1, 0, 0, 0, 1);
    step(1, 0, 32'h01, 1, 0, 1);
    step(0, 0, 0, 1, 0, 1);
    chk("R4 zero count blocks", req_ok, 0);
    step(1, 0, 32'h10, 0, 0, 0);         // R2 direction memory
    chk("R2 dir", dir_mem, 1);
    // odd count half point
    step(1, 1, 7, 0, 0, 1);
    step(1, 0, 32'h05, 0, 0, 2);
    for (int i = 0; i < 5; i++) step(0, 0, 0, (i % 2) == 0, 0, 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule